// File: doc/BRIEF.md
# Prescaled Timer/Counter with Match Outputs and Edge Capture

This block keeps a counter that advances once for every programmable number of source events. The source is either the block clock (timer mode) or rising edges on an external count pin (counter mode). Four compare channels watch the counter. On a hit, each channel can flag an interrupt, zero the counter and halt it. Each channel also drives its own output pin, which it can force low, force high, flip, or leave alone.

Two capture channels sit alongside the compare channels. Each one copies the counter value on a selected edge of its input pin. All external pins pass through a two-flop synchronizer before edge detection.

Software reaches the registers through a valid/ready request channel. Reads are answered on a valid/ready response channel. A request is accepted only when no response is waiting or the waiting one is being taken in the same cycle, so a stalled response back-pressures the request side. A write takes effect at its acceptance edge. Every read returns exactly one response, in order, and the response stays valid and unchanged until it is taken.

Top module: `tmr_match_capture`

## Requirements
- R1: After reset every register reads zero, all match pins are low, irq is low and no response is pending.
- R2: The counter advances by one on each source event that finds the prescale count (word 2) equal to or above the prescale limit (word 1), and that event returns the prescale count to zero. Any other source event increments the prescale count. The counter value is readable at word 3.
- R3: Control word 0 holds three fields: bit 0 run, bit 1 clear, bit 2 mode. With mode 0, each clock cycle while running is a source event. With mode 1, each synchronized rising edge on count_in is a source event, and the clock alone counts nothing.
- R4: A compare hit happens when the counter advances while it equals the match value of channel i (word 8+i). If that channel's interrupt enable is set, the hit sets status bit i (word 4). Counting continues past the hit.
- R5: A hit on a channel whose reset enable is set loads zero into the counter instead of the incremented value.
- R6: A hit on a channel whose stop enable is set holds the counter at its current value and clears the run bit. This takes priority over a write to the run bit in the same cycle. With both reset and stop enabled, the counter becomes zero and halts.
- R7: Channel configuration (word 5) uses 5 bits per channel at offset 5*i: bit 0 interrupt enable, bit 1 reset enable, bit 2 stop enable, bits 4:3 pin action. The pin action codes are 00 none, 01 drive low, 10 drive high, 11 toggle, and the action is applied to match_out[i] on each hit.
- R8: Capture configuration (word 6) uses 3 bits per channel at offset 3*j: bit 0 rising enable, bit 1 falling enable, bit 2 interrupt enable. An enabled edge on cap_in[j] copies the counter into word 16+j. With both edges enabled, either edge captures, and an edge that is not enabled changes nothing.
- R9: A capture with its interrupt enable set sets status bit 4+j.
- R10: Writing 1 to a status bit clears it, and writing 0 leaves it unchanged. irq is high exactly when any status bit is set.
- R11: While the clear bit is set, the counter and the prescale count are held at zero, even with run set.
- R12: The counter wraps from all ones to zero.
- R13: req_ready equals !rsp_valid || rsp_ready. A response held off by rsp_ready low keeps rsp_valid high and rsp_data stable.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| req_valid | input | 1 | Register request valid |
| req_ready | output | 1 | Register request accepted |
| req_write | input | 1 | 1 write, 0 read |
| req_addr | input | 5 | Word address |
| req_wdata | input | 32 | Write data |
| rsp_valid | output | 1 | Read response valid |
| rsp_ready | input | 1 | Read response taken |
| rsp_data | output | 32 | Read data |
| count_in | input | 1 | External count source |
| cap_in | input | 2 | Capture inputs |
| match_out | output | 4 | Compare-driven pins |
| irq | output | 1 | Interrupt, OR of status bits |

## Verification
The bench builds the block with an 8-bit counter, while the match and capture channel counts and the 32-bit prescaler keep their defaults. The narrow counter makes the wrap from all ones to zero reachable in a couple of hundred cycles. It also makes every other scenario observable through exact counter values after a known number of enabled cycles. A reset-period toggle sequence, stop alone, stop with reset, edge-selective captures and a stalled read response each get their own exact expected values.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
  localparam int ADDR_W = 5;
  localparam int DATA_W = 32;

  localparam int A_CTRL  = 0;
  localparam int A_PRE   = 1;
  localparam int A_PCNT  = 2;
  localparam int A_CNT   = 3;
  localparam int A_STAT  = 4;
  localparam int A_MCFG  = 5;
  localparam int A_CCFG  = 6;
  localparam int A_MATCH = 8;
  localparam int A_CAP   = 16;

  typedef enum logic [1:0] {
    ACT_NONE   = 2'b00,
    ACT_LOW    = 2'b01,
    ACT_HIGH   = 2'b10,
    ACT_TOGGLE = 2'b11
  } pin_act_e;

  // packed msb-first: act[4:3], stop[2], rst[1], irq[0]
  typedef struct packed {
    pin_act_e act;
    logic     stop_en;
    logic     rst_en;
    logic     irq_en;
  } match_cfg_t;

  // irq[2], fall[1], rise[0]
  typedef struct packed {
    logic irq_en;
    logic fall_en;
    logic rise_en;
  } cap_cfg_t;

  localparam int MCFG_W = $bits(match_cfg_t);
  localparam int CCFG_W = $bits(cap_cfg_t);
endpackage

// File: rtl/tmr_edge_sync.sv
module tmr_edge_sync #(
  parameter int N = 1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] din,
  output logic [N-1:0] rise,
  output logic [N-1:0] fall
);
  logic [N-1:0] s1, s2, s3;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1 <= '0;
      s2 <= '0;
      s3 <= '0;
    end else begin
      s1 <= din;
      s2 <= s1;
      s3 <= s2;
    end
  end

  assign rise = s2 & ~s3;
  assign fall = ~s2 & s3;
endmodule

// File: rtl/tmr_count_core.sv
module tmr_count_core #(
  parameter int CNT_W = 32,
  parameter int PRE_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic             hold_clr,
  input  logic             src_tick,
  input  logic [PRE_W-1:0] pre_lim,
  input  logic             hit_rst,
  input  logic             hit_stop,
  output logic             inc,
  output logic [CNT_W-1:0] cnt,
  output logic [PRE_W-1:0] pcnt
);
  assign inc = run && !hold_clr && src_tick && (pcnt >= pre_lim);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt  <= '0;
      pcnt <= '0;
    end else if (hold_clr) begin
      cnt  <= '0;
      pcnt <= '0;
    end else if (inc) begin
      pcnt <= '0;
      if (hit_rst)       cnt <= '0;
      else if (!hit_stop) cnt <= cnt + 1'b1;
    end else if (run && src_tick) begin
      pcnt <= pcnt + 1'b1;
    end
  end

  // R11
  hold_clear_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    hold_clr |=> (cnt == '0 && pcnt == '0));

  // R2
  step_one_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (inc && !hit_rst && !hit_stop) |=> cnt == CNT_W'($past(cnt) + 1'b1));

  // R2
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!inc && !hold_clr) |=> $stable(cnt));

  // R5
  hit_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (inc && hit_rst) |=> cnt == '0);
endmodule

// File: rtl/tmr_match_chan.sv
module tmr_match_chan
  import tmr_pkg::*;
#(
  parameter int CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             inc,
  input  logic [CNT_W-1:0] cnt,
  input  logic [CNT_W-1:0] match_val,
  input  match_cfg_t       cfg,
  output logic             evt,
  output logic             pin_q
);
  assign evt = inc && (cnt == match_val);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pin_q <= 1'b0;
    end else if (evt) begin
      case (cfg.act)
        ACT_LOW:    pin_q <= 1'b0;
        ACT_HIGH:   pin_q <= 1'b1;
        ACT_TOGGLE: pin_q <= ~pin_q;
        default:    pin_q <= pin_q;
      endcase
    end
  end

  // R7
  pin_toggle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (evt && cfg.act == ACT_TOGGLE) |=> pin_q != $past(pin_q));

  // R7
  pin_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (evt && cfg.act == ACT_HIGH) |=> pin_q);

  // R7
  pin_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!evt || cfg.act == ACT_NONE) |=> $stable(pin_q));
endmodule

// File: rtl/tmr_capture_chan.sv
module tmr_capture_chan
  import tmr_pkg::*;
#(
  parameter int CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             rise,
  input  logic             fall,
  input  cap_cfg_t         cfg,
  input  logic [CNT_W-1:0] cnt,
  output logic             hit,
  output logic [CNT_W-1:0] cap_q
);
  assign hit = (rise && cfg.rise_en) || (fall && cfg.fall_en);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   cap_q <= '0;
    else if (hit) cap_q <= cnt;
  end

  // R8
  cap_value_chk: assert property (@(posedge clk) disable iff (!rst_n)
    hit |=> cap_q == $past(cnt));

  // R8
  cap_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !hit |=> $stable(cap_q));
endmodule

// File: rtl/tmr_match_capture.sv
module tmr_match_capture
  import tmr_pkg::*;
#(
  parameter int CNT_W   = 32,
  parameter int PRE_W   = 32,
  parameter int N_MATCH = 4,
  parameter int N_CAP   = 2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               req_valid,
  output logic               req_ready,
  input  logic               req_write,
  input  logic [ADDR_W-1:0]  req_addr,
  input  logic [DATA_W-1:0]  req_wdata,
  output logic               rsp_valid,
  input  logic               rsp_ready,
  output logic [DATA_W-1:0]  rsp_data,
  input  logic               count_in,
  input  logic [N_CAP-1:0]   cap_in,
  output logic [N_MATCH-1:0] match_out,
  output logic               irq
);
  localparam int STAT_W = N_MATCH + N_CAP;
  localparam int SYNC_N = N_CAP + 1;

  logic              ctrl_run, ctrl_clr, ctrl_mode;
  logic [PRE_W-1:0]  pre_lim;
  logic [STAT_W-1:0] stat_q;
  logic [CNT_W-1:0]  match_val [N_MATCH];
  match_cfg_t        mcfg      [N_MATCH];
  cap_cfg_t          ccfg      [N_CAP];
  logic [CNT_W-1:0]  cap_val   [N_CAP];

  logic [N_MATCH-1:0] evt, rst_req, stop_req;
  logic [N_CAP-1:0]   cap_hit;
  logic               hit_rst, stop_hit, inc, src_tick;
  logic [CNT_W-1:0]   cnt;
  logic [PRE_W-1:0]   pcnt;
  logic [SYNC_N-1:0]  s_rise, s_fall;

  logic acc, wr_en, rd_en;
  logic [DATA_W-1:0] rdata;

  tmr_edge_sync #(.N(SYNC_N)) u_sync (
    .clk  (clk),
    .rst_n(rst_n),
    .din  ({cap_in, count_in}),
    .rise (s_rise),
    .fall (s_fall)
  );

  assign src_tick = ctrl_mode ? s_rise[0] : 1'b1;

  tmr_count_core #(.CNT_W(CNT_W), .PRE_W(PRE_W)) u_core (
    .clk     (clk),
    .rst_n   (rst_n),
    .run     (ctrl_run),
    .hold_clr(ctrl_clr),
    .src_tick(src_tick),
    .pre_lim (pre_lim),
    .hit_rst (hit_rst),
    .hit_stop(stop_hit),
    .inc     (inc),
    .cnt     (cnt),
    .pcnt    (pcnt)
  );

  for (genvar i = 0; i < N_MATCH; i++) begin : g_match
    tmr_match_chan #(.CNT_W(CNT_W)) u_mch (
      .clk      (clk),
      .rst_n    (rst_n),
      .inc      (inc),
      .cnt      (cnt),
      .match_val(match_val[i]),
      .cfg      (mcfg[i]),
      .evt      (evt[i]),
      .pin_q    (match_out[i])
    );
    assign rst_req[i]  = evt[i] && mcfg[i].rst_en;
    assign stop_req[i] = evt[i] && mcfg[i].stop_en;
  end

  for (genvar j = 0; j < N_CAP; j++) begin : g_cap
    tmr_capture_chan #(.CNT_W(CNT_W)) u_cch (
      .clk  (clk),
      .rst_n(rst_n),
      .rise (s_rise[j+1]),
      .fall (s_fall[j+1]),
      .cfg  (ccfg[j]),
      .cnt  (cnt),
      .hit  (cap_hit[j]),
      .cap_q(cap_val[j])
    );
  end

  assign hit_rst  = |rst_req;
  assign stop_hit = |stop_req;

  // register access
  assign req_ready = !rsp_valid || rsp_ready;
  assign acc   = req_valid && req_ready;
  assign wr_en = acc && req_write;
  assign rd_en = acc && !req_write;

  logic [STAT_W-1:0] set_mask, clr_mask;
  always_comb begin
    for (int i = 0; i < N_MATCH; i++) set_mask[i] = evt[i] && mcfg[i].irq_en;
    for (int j = 0; j < N_CAP; j++)   set_mask[N_MATCH+j] = cap_hit[j] && ccfg[j].irq_en;
    clr_mask = (wr_en && int'(req_addr) == A_STAT) ? req_wdata[STAT_W-1:0] : '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_run  <= 1'b0;
      ctrl_clr  <= 1'b0;
      ctrl_mode <= 1'b0;
      pre_lim   <= '0;
      stat_q    <= '0;
      for (int i = 0; i < N_MATCH; i++) begin
        match_val[i] <= '0;
        mcfg[i]      <= '0;
      end
      for (int j = 0; j < N_CAP; j++) ccfg[j] <= '0;
    end else begin
      if (wr_en) begin
        if (int'(req_addr) == A_CTRL) begin
          ctrl_run  <= req_wdata[0];
          ctrl_clr  <= req_wdata[1];
          ctrl_mode <= req_wdata[2];
        end
        if (int'(req_addr) == A_PRE) pre_lim <= req_wdata[PRE_W-1:0];
        for (int i = 0; i < N_MATCH; i++) begin
          if (int'(req_addr) == A_MCFG)
            mcfg[i] <= match_cfg_t'(req_wdata[MCFG_W*i +: MCFG_W]);
          if (int'(req_addr) == A_MATCH + i)
            match_val[i] <= req_wdata[CNT_W-1:0];
        end
        for (int j = 0; j < N_CAP; j++)
          if (int'(req_addr) == A_CCFG)
            ccfg[j] <= cap_cfg_t'(req_wdata[CCFG_W*j +: CCFG_W]);
      end
      if (stop_hit) ctrl_run <= 1'b0;
      stat_q <= (stat_q & ~clr_mask) | set_mask;
    end
  end

  always_comb begin
    rdata = '0;
    case (int'(req_addr))
      A_CTRL: rdata[2:0] = {ctrl_mode, ctrl_clr, ctrl_run};
      A_PRE:  rdata[PRE_W-1:0] = pre_lim;
      A_PCNT: rdata[PRE_W-1:0] = pcnt;
      A_CNT:  rdata[CNT_W-1:0] = cnt;
      A_STAT: rdata[STAT_W-1:0] = stat_q;
      default: rdata = '0;
    endcase
    for (int i = 0; i < N_MATCH; i++) begin
      if (int'(req_addr) == A_MCFG)    rdata[MCFG_W*i +: MCFG_W] = mcfg[i];
      if (int'(req_addr) == A_MATCH + i) rdata[CNT_W-1:0] = match_val[i];
    end
    for (int j = 0; j < N_CAP; j++) begin
      if (int'(req_addr) == A_CCFG)   rdata[CCFG_W*j +: CCFG_W] = ccfg[j];
      if (int'(req_addr) == A_CAP + j) rdata[CNT_W-1:0] = cap_val[j];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_data  <= '0;
    end else if (rd_en) begin
      rsp_valid <= 1'b1;
      rsp_data  <= rdata;
    end else if (rsp_ready) begin
      rsp_valid <= 1'b0;
    end
  end

  assign irq = |stat_q;

  // R6
  stop_clears_run_chk: assert property (@(posedge clk) disable iff (!rst_n)
    stop_hit |=> !ctrl_run);

  // R13
  rsp_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ready) |=> (rsp_valid && $stable(rsp_data)));

  // R10
  stat_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (|set_mask) |=> irq);
endmodule

// File: tb/test_tmr_match_capture.sv
module test_tmr_match_capture;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0, req_write = 1'b0, rsp_ready = 1'b1;
  logic [4:0]  req_addr = '0;
  logic [31:0] req_wdata = '0;
  logic        req_ready, rsp_valid, irq;
  logic [31:0] rsp_data;
  logic        count_in = 1'b0;
  logic [1:0]  cap_in = '0;
  logic [3:0]  match_out;

  int errors = 0, checks = 0;
  logic [31:0] exp_q[$];
  string       tag_q[$];
  bit          done = 1'b0;

  always #4 clk = ~clk;

  tmr_match_capture #(.CNT_W(8)) i_tmr_match_capture (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
    .req_addr(req_addr), .req_wdata(req_wdata),
    .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_data(rsp_data),
    .count_in(count_in), .cap_in(cap_in), .match_out(match_out), .irq(irq)
  );

  task automatic chk(input logic [31:0] act, input logic [31:0] exp, input string tag);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic bus(input logic wr, input int a, input logic [31:0] d);
    @(negedge clk);
    req_valid = 1'b1; req_write = wr; req_addr = 5'(a); req_wdata = d;
    #1;
    while (!req_ready) begin @(negedge clk); #1; end
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  task automatic wr(input int a, input logic [31:0] d);
    bus(1'b1, a, d);
  endtask

  // driver: expected item goes to the scoreboard queue
  task automatic rd(input int a, input logic [31:0] exp, input string tag);
    exp_q.push_back(exp);
    tag_q.push_back(tag);
    bus(1'b0, a, '0);
  endtask

  task automatic wait_n(input int n);
    repeat (n) @(negedge clk);
  endtask

  // monitor
  always @(negedge clk) begin
    #2;
    if (rst_n && rsp_valid && rsp_ready) begin
      if (exp_q.size() == 0) begin
        checks++; errors++;
        $display("FAIL R13: unexpected response %0h", rsp_data);
      end else begin
        chk(rsp_data, exp_q.pop_front(), tag_q.pop_front());
      end
    end
  end

  task automatic finish_run();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  initial begin
    repeat (60000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual=hung expected=done");
      finish_run();
    end
  end

  initial begin
    wait_n(5);
    rst_n = 1'b1;
    wait_n(2);
    // reset state
    chk(match_out, 0, "R1 pins");
    chk(irq, 0, "R1 irq");
    chk(rsp_valid, 0, "R1 rsp_valid");
    rd(0, 0, "R1 ctrl");
    rd(3, 0, "R1 count");
    rd(4, 0, "R1 status");
    rd(16, 0, "R1 capture0");

    // prescale 3, 22 enabled cycles
    wr(1, 3);
    wr(0, 1);
    wait_n(20);
    wr(0, 0);
    rd(3, 5, "R2 count");
    rd(2, 2, "R2 prescale count");

    // hold clear
    wr(0, 2);
    rd(3, 0, "R11 count");
    rd(2, 0, "R11 pcount");
    wr(0, 3);
    wait_n(5);
    rd(3, 0, "R11 count while run");
    wr(0, 0);

    // reset on match 4, toggle, irq; 17 ticks
    wr(1, 0);
    wr(9, 4);
    wr(5, 32'h360);
    wr(0, 1);
    wait_n(15);
    wr(0, 0);
    rd(3, 2, "R5 count period");
    chk(match_out[1], 1, "R7 toggle x3");
    rd(4, 32'h2, "R4 status bit1");
    chk(irq, 1, "R10 irq set");
    wr(4, 32'h2);
    rd(4, 0, "R10 w1c");
    chk(irq, 0, "R10 irq clear");

    // continue past match, drive high; 10 ticks
    wr(0, 2); wr(0, 0);
    wr(5, 32'h4400);
    wr(10, 3);
    wr(0, 1);
    wait_n(8);
    wr(0, 0);
    rd(3, 10, "R4 continues");
    chk(match_out[2], 1, "R7 drive high");
    chk(match_out[1], 1, "R7 none keeps");
    rd(4, 32'h4, "R4 status bit2");
    // drive low, no irq
    wr(5, 32'h2000);
    wr(0, 2); wr(0, 0);
    wr(0, 1);
    wait_n(4);
    wr(0, 0);
    chk(match_out[2], 0, "R7 drive low");
    rd(4, 32'h4, "R4 irq gated");
    wr(4, 32'h3F);

    // stop at 6
    wr(0, 2); wr(0, 0);
    wr(5, 32'h4);
    wr(8, 6);
    wr(0, 1);
    wait_n(20);
    rd(3, 6, "R6 stop holds");
    rd(0, 0, "R6 run cleared");
    wr(5, 32'h6);
    wr(0, 1);
    wait_n(10);
    rd(3, 0, "R6 reset then halt");
    rd(0, 0, "R6 run cleared 2");
    rd(4, 0, "R4 no irq when disabled");
    wr(5, 0);

    // counter mode, prescale 1, six edges
    wr(0, 2);
    wr(1, 1);
    wr(0, 5);
    wait_n(10);
    rd(3, 0, "R3 clock ignored");
    for (int k = 0; k < 6; k++) begin
      @(negedge clk) count_in = 1'b1;
      wait_n(3);
      count_in = 1'b0;
      wait_n(3);
    end
    wait_n(6);
    rd(3, 3, "R3 edge count");
    rd(2, 0, "R3 pcount");
    wr(0, 0);

    // captures with counter at 3
    wr(6, 32'h15);
    @(negedge clk) cap_in[0] = 1'b1;
    wait_n(6);
    rd(16, 3, "R8 rise capture");
    rd(4, 32'h10, "R9 capture irq");
    @(negedge clk) cap_in[1] = 1'b1;
    wait_n(6);
    rd(17, 0, "R8 rise ignored");
    @(negedge clk) cap_in[1] = 1'b0;
    wait_n(6);
    rd(17, 3, "R8 fall capture");
    rd(4, 32'h10, "R9 no irq when disabled");
    wr(0, 2); wr(0, 0);
    @(negedge clk) cap_in[0] = 1'b0;
    wait_n(6);
    rd(16, 3, "R8 fall ignored");
    wr(6, 32'h1D);
    @(negedge clk) cap_in[1] = 1'b1;
    wait_n(6);
    rd(17, 0, "R8 both edges");

    // wrap, 258 ticks
    wr(6, 0);
    wr(1, 0);
    wr(0, 1);
    wait_n(256);
    wr(0, 0);
    rd(3, 2, "R12 wrap");

    // back-pressure
    @(negedge clk) rsp_ready = 1'b0;
    rd(9, 4, "R13 stalled read");
    for (int k = 0; k < 4; k++) begin
      chk(rsp_valid, 1, "R13 valid held");
      chk(req_ready, 0, "R13 ready low");
      chk(rsp_data, 4, "R13 data stable");
      @(negedge clk);
    end
    rsp_ready = 1'b1;
    wait_n(4);
    chk(exp_q.size(), 0, "R13 drained");
    done = 1'b1;
    finish_run();
  end
endmodule